// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends words on an asynchronous serial line. A host places a word in a one-word holding buffer through a single-cycle write strobe. An optional ninth data bit and a 9-bit mode select travel with the write. Whenever the shifter is free, the engine moves the buffered word into a shift register and wraps it in a low start bit and a high stop bit. It then sends the frame least significant bit first, one bit per baud tick. Because of the holding buffer, the host can queue the next word while the current frame is on the line. The frames then follow each other with no idle gap.

Two flags report progress. `buf_empty` says the holding buffer can take a word. `tx_done` says the line has gone quiet after a full stop period. A transmit enable owns the pin. When it is set, the pin is an output carrying the serial line. When it is cleared, the pin falls back to the general-purpose value and direction, and any frame in flight is dropped. Baud generation is outside the block: `baud_tick` is a one-cycle pulse per bit period.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset `buf_empty` is 1 and `tx_done` is 0. While the engine is idle and enabled, `pin_out` is 1.
- R2: An 8-bit frame is 10 bits on the line: 0 (start), the 8 data bits least significant first, then 1 (stop).
- R3: With `wr_wide`=1 the frame is 11 bits. `wr_bit9` is sent after bit 7 of the data and before the stop bit. The ninth bit and the mode are captured at the write.
- R4: A write with the enable set makes `buf_empty` 0 in the next cycle. When the shifter is idle, the word moves into the shift register one cycle later and `buf_empty` returns to 1. The start bit appears at the first baud tick after that move. `buf_empty` then stays 1 until the next write.
- R5: A word written during a frame is loaded when the stop bit goes on the line. Its start bit follows exactly one baud tick later.
- R6: A write while the buffer is still full replaces the buffered word. The replaced word is never sent.
- R7: `tx_done` becomes 1 at the baud tick after the stop bit's tick, and only if no word is waiting.
- R8: `tx_done` is cleared by a one-cycle `clr_done`=1 or by an accepted write. A set in the same cycle wins over the clear.
- R9: With `tx_en`=1, `pin_oe` is 1 and `pin_out` carries the serial line. With `tx_en`=0, `pin_oe` equals `gp_dir` and `pin_out` equals `gp_out`.
- R10: Clearing `tx_en` aborts any frame and empties the buffer, and the line returns high. Writes made while `tx_en` is 0 are ignored.
- R11: While enabled, the serial line changes only in cycles that carry a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | DATA_W | Data word to send |
| wr_bit9 | input | 1 | Ninth data bit, used in 9-bit mode |
| wr_wide | input | 1 | 1 selects 9-bit words for this write |
| clr_done | input | 1 | Write-one-to-clear for `tx_done` |
| tx_en | input | 1 | Transmitter enable and pin ownership |
| gp_out | input | 1 | General-purpose pin value when disabled |
| gp_dir | input | 1 | General-purpose pin direction when disabled (1 = output) |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| buf_empty | output | 1 | Holding buffer can accept a word |
| tx_done | output | 1 | Transmission complete |

## Verification
The frame shape is tried with single words whose data patterns put the start and stop edges next to equal or opposite data bits (0xA5, 0xFF, 0x3C). A word with the ninth bit 1 and a word with it 0 show that bit landing in the correct slot. A second word queued during a frame exposes any extra idle tick or doubled stop bit between frames. Three writes in a row, with the middle one overwritten, show that only the latest buffered word is sent. Aborts with a word still in the buffer, and writes made while disabled, must leave no trace on the line. Single frames are timed tick by tick to separate the `buf_empty` and `tx_done` instants.

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              wr_wide,
  input  logic              clr_done,
  input  logic              tx_en,
  input  logic              gp_out,
  input  logic              gp_dir,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              buf_empty,
  output logic              tx_done
);
  localparam int FRM_W = DATA_W + 3;
  localparam int CNT_W = $clog2(FRM_W + 1);
  localparam logic [CNT_W-1:0] LEN_N = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_W = CNT_W'(DATA_W + 3);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_STOP} state_t;

  state_t             state;
  logic               buf_full;
  logic [DATA_W-1:0]  buf_word;
  logic               buf_b9;
  logic               buf_wide;
  logic [FRM_W-1:0]   shreg;
  logic [CNT_W-1:0]   bits_left;
  logic               line_q;
  logic               done_q;

  wire accept    = wr_en & tx_en;
  wire last_tick = (state == S_SHIFT) & baud_tick & (bits_left == CNT_W'(1));
  wire load      = tx_en & buf_full & ((state != S_SHIFT) | last_tick);
  wire stop_end  = (state == S_STOP) & baud_tick & ~load;
  wire eng_idle  = (state == S_IDLE);

  wire [FRM_W-1:0] next_frame = {1'b1, (buf_wide ? buf_b9 : 1'b1), buf_word, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_word <= '0;
      buf_b9   <= 1'b0;
      buf_wide <= 1'b0;
    end else if (!tx_en) begin
      buf_full <= 1'b0;
    end else if (accept) begin
      buf_full <= 1'b1;
      buf_word <= wr_data;
      buf_b9   <= wr_bit9;
      buf_wide <= wr_wide;
    end else if (load) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      shreg     <= '1;
      bits_left <= '0;
      line_q    <= 1'b1;
    end else if (!tx_en) begin
      state     <= S_IDLE;
      bits_left <= '0;
      line_q    <= 1'b1;
    end else begin
      if (state == S_SHIFT && baud_tick) begin
        line_q    <= shreg[0];
        shreg     <= {1'b1, shreg[FRM_W-1:1]};
        bits_left <= bits_left - CNT_W'(1);
        if (last_tick) state <= S_STOP;
      end
      if (stop_end) state <= S_IDLE;
      if (load) begin
        shreg     <= next_frame;
        bits_left <= buf_wide ? LEN_W : LEN_N;
        state     <= S_SHIFT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 done_q <= 1'b0;
    else if (stop_end)          done_q <= 1'b1;
    else if (clr_done | accept) done_q <= 1'b0;
  end

  assign buf_empty = ~buf_full;
  assign tx_done   = done_q;
  assign pin_oe    = tx_en ? 1'b1 : gp_dir;
  assign pin_out   = tx_en ? line_q : gp_out;

endmodule

module uart_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic wr_en,
  input logic tx_en,
  input logic buf_empty,
  input logic tx_done,
  input logic line_q,
  input logic eng_idle
);
  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_en) |=> !buf_empty);

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (buf_empty && line_q));

  a_r11_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !baud_tick) |=> $stable(line_q));

  a_r7_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> ($past(baud_tick) && line_q));

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> line_q);
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
  .tx_en(tx_en), .buf_empty(buf_empty), .tx_done(tx_done),
  .line_q(line_q), .eng_idle(eng_idle)
);

// File: tb/uart_tx_dbuf_tb.sv
module uart_tx_dbuf_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, baud_tick, wr_en, wr_bit9, wr_wide, clr_done, tx_en, gp_out, gp_dir;
  logic [7:0] wr_data;
  logic       pin_out, pin_oe, buf_empty, tx_done;

  uart_tx_dbuf #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .wr_wide(wr_wide),
    .clr_done(clr_done), .tx_en(tx_en), .gp_out(gp_out), .gp_dir(gp_dir),
    .pin_out(pin_out), .pin_oe(pin_oe), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_frame_q[$];
  int          exp_len_q[$];
  bit          exp_b2b_q[$];
  bit          abort_ok = 0;
  bit          finished = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic wait_tick();
    bit t;
    do begin @(posedge clk); t = baud_tick; end while (!t);
    @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, bit b9, bit wide, bit expect_it, bit b2b);
    wr_data = d; wr_bit9 = b9; wr_wide = wide; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (expect_it) begin
      exp_frame_q.push_back({1'b1, (wide ? b9 : 1'b1), d, 1'b0});
      exp_len_q.push_back(wide ? 11 : 10);
      exp_b2b_q.push_back(b2b);
    end
  endtask

  task automatic wait_done(string req);
    for (int i = 0; i < 60 && !tx_done; i++) wait_tick();
    check(req, tx_done, 1);
  endtask

  // Monitor: pops expected frames and compares what appears on the pin
  initial begin
    int tix = 0;
    int stop_t = -100;
    bit in_fr = 0;
    int got_n = 0;
    int el = 0;
    logic [10:0] got, ef;
    bit t, en, eb;
    forever begin
      @(posedge clk);
      t = baud_tick; en = tx_en;
      #2;
      if (!en || !rst_n) in_fr = 0;
      else if (t) begin
        tix++;
        if (!in_fr) begin
          if (pin_out == 1'b0) begin
            in_fr = 1; got = '0; got_n = 1;
            if (exp_frame_q.size() == 0) begin
              el = 99;
              if (!abort_ok) check("R2 unexpected start bit", 1, 0);
            end else begin
              ef = exp_frame_q.pop_front();
              el = exp_len_q.pop_front();
              eb = exp_b2b_q.pop_front();
              if (eb) check("R5 gap between stop and next start", tix - stop_t, 1);
            end
          end
        end else if (el != 99) begin
          got[got_n] = pin_out;
          got_n++;
          if (got_n == el) begin
            in_fr = 0;
            stop_t = tix;
            if (el == 11) check("R3 9-bit frame", int'(got), int'(ef));
            else          check("R2 8-bit frame", int'(got[9:0]), int'(ef[9:0]));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; wr_bit9 = 0; wr_wide = 0;
    clr_done = 0; tx_en = 0; gp_out = 0; gp_dir = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 buf_empty after reset", buf_empty, 1);
    check("R1 tx_done after reset", tx_done, 0);
    check("R9 pin_oe follows gp_dir", pin_oe, 0);

    gp_dir = 1; gp_out = 1; #1;
    check("R9 pin_oe follows gp_dir", pin_oe, 1);
    check("R9 pin_out follows gp_out", pin_out, 1);
    gp_out = 0; #1;
    check("R9 pin_out follows gp_out", pin_out, 0);

    @(negedge clk);
    send(8'h77, 0, 0, 0, 0);
    check("R10 write ignored while disabled", buf_empty, 1);

    tx_en = 1;
    @(negedge clk);
    check("R9 pin_oe when enabled", pin_oe, 1);
    check("R1 idle line high", pin_out, 1);
    repeat (15) wait_tick();
    check("R10 no frame from ignored write", pin_out, 1);

    // R4 / R7 timing of one frame
    wait_tick();
    send(8'hA5, 0, 0, 1, 0);
    check("R4 buf_empty low after write", buf_empty, 0);
    @(negedge clk);
    check("R4 buf_empty high after transfer", buf_empty, 1);
    check("R4 line still high before tick", pin_out, 1);
    wait_tick();
    check("R4 start bit at first tick", pin_out, 0);
    repeat (9) wait_tick();
    check("R2 stop bit on line", pin_out, 1);
    check("R7 tx_done not yet", tx_done, 0);
    check("R4 buf_empty stays set", buf_empty, 1);
    wait_tick();
    check("R7 tx_done after stop period", tx_done, 1);

    // R8 clearing
    clr_done = 1;
    @(negedge clk);
    clr_done = 0;
    check("R8 clr_done clears", tx_done, 0);
    wait_tick();
    send(8'hFF, 0, 0, 1, 0);
    wait_done("R7 done after 0xFF");
    send(8'h3C, 1, 1, 1, 0);
    check("R8 write clears tx_done", tx_done, 0);
    wait_done("R7 done after 9-bit word");
    send(8'hFF, 0, 1, 1, 0);
    wait_done("R7 done after 9-bit word with bit9=0");

    // R5 back-to-back
    send(8'h5A, 0, 0, 1, 0);
    repeat (3) wait_tick();
    send(8'h81, 1, 1, 1, 1);
    repeat (11) wait_tick();
    check("R7 no done between queued frames", tx_done, 0);
    wait_done("R7 done after queued frames");

    // R6 overwrite of a full buffer
    send(8'h11, 0, 0, 1, 0);
    repeat (2) wait_tick();
    send(8'h22, 0, 0, 0, 0);
    send(8'h33, 0, 0, 1, 1);
    wait_done("R6 done after overwrite");
    check("R6 expected queue drained", exp_frame_q.size(), 0);

    // R10 abort mid-frame with a word pending
    abort_ok = 1;
    send(8'h0F, 0, 0, 0, 0);
    repeat (3) wait_tick();
    send(8'hF0, 0, 0, 0, 0);
    wait_tick();
    tx_en = 0;
    @(negedge clk);
    check("R10 buffer emptied by abort", buf_empty, 1);
    tx_en = 1;
    @(negedge clk);
    abort_ok = 0;
    check("R10 line high after abort", pin_out, 1);
    repeat (20) wait_tick();
    check("R10 pending word dropped", pin_out, 1);
    check("R10 no completion after abort", tx_done, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule